// File: doc/BRIEF.md
# Single-Lane SPI Macro Transaction Engine

This block is a memory-mapped SPI master that runs one complete flash-style transaction at a time. Software places every byte it wants to send (opcode, address, dummy bytes and write payload) at the start of a 128-byte shared buffer. It then programs how many bytes go out and how many come back, and sets the enable and trigger bits. The engine lowers chip select, shifts the outgoing bytes MSB first on one data line, and keeps clocking for the requested number of incoming bytes. It stores each received byte in the same buffer, directly after the last outgoing byte.

The serial clock runs in mode 0 at half the core clock, with one core cycle low and one high per bit. After the last bit the engine holds chip select high for a programmable deselect time, then returns to idle. A two-stage handshake is visible to software. The ready flag rises when a trigger is accepted and the in-progress flag falls once the transaction and its deselect time are complete. A software-reset bit aborts any transfer and returns the state machine to idle.

Top module: `spi_macro_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the control, misc and status registers all read zero.
- R2: A write to the control register (0x500) with bit 2 set starts a transaction only if the same write sets bit 3 (enable), the engine is idle, and the output length plus the input length is between 1 and 128. Any other trigger is ignored: ready and in-progress stay 0 and chip select stays high.
- R3: In the cycle after an accepted trigger, control bit 1 (ready) and bit 0 (in progress) both read 1. In progress returns to 0 when the transaction ends, while ready stays 1 until a control write clears bit 3.
- R4: While chip select is low the engine gives exactly 8 x (output + input length) clock pulses. The first output-length bytes are sent MSB first, and byte p is taken from bits [8(p mod 4)+7 : 8(p mod 4)] of buffer word p/4. The buffer is mapped at 0x800.
- R5: The byte received during transaction byte position p, for p from the output length up to the total length minus 1, is written to buffer byte p with the same packing. All other buffer bytes keep their contents.
- R6: The bus runs in SPI mode 0. The clock is low whenever chip select is high, and data out is set up before each rising clock edge and changes only after a falling edge.
- R7: After a transaction, chip select stays high for at least D+1 core cycles, where D is misc bits [4:0]. In progress stays 1 through this whole time.
- R8: Writing misc (0x538) with bit 28 set aborts any transfer. From the next cycle chip select is high, ready and in progress are 0, and the status field is 0. Bit 28 always reads 0.
- R9: Misc bits [26:25], [9:8] and [4:0] read back what was written, and all other misc bits read 0.
- R10: Status bits [3:0] at 0x550 read 1 while shifting, 2 during the deselect time, and 0 when idle.
- R11: The output length (0x504) and input length (0x508) registers hold 8 bits each and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach from the ports is a new trigger arriving right after in-progress falls. Only then does the deselect time set the spacing between chip-select frames; any later trigger hides a short gap behind register-access latency. The stimulus sets the deselect count to its maximum, polls the control register every cycle, and triggers with enable and trigger in one write on the first idle read. It then measures the high time of chip select on the wire. Random lengths that fill the buffer to the last byte, together with an abort in the middle of a 128-byte frame, cover the placement of received bytes and recovery from software reset.

// File: rtl/spi_mac_pkg.sv
package spi_mac_pkg;

  localparam int OFS_CTL  = 'h500;
  localparam int OFS_OLEN = 'h504;
  localparam int OFS_ILEN = 'h508;
  localparam int OFS_MISC = 'h538;
  localparam int OFS_STAT = 'h550;
  localparam int OFS_BUF  = 'h800;

  localparam int CTL_EN   = 3;
  localparam int CTL_TRIG = 2;
  localparam int MISC_SWRST = 28;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SHIFT = 4'd1,
    ST_GAP   = 4'd2
  } eng_state_e;

endpackage

// File: rtl/spi_mac_buffer.sv
module spi_mac_buffer #(
  parameter int BUF_BYTES = 128,
  localparam int WORDS  = BUF_BYTES / 4,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int PTR_W  = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [WIDX_W-1:0] cpu_widx,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic [PTR_W-1:0]  eng_ridx,
  output logic [7:0]        eng_rdata,
  input  logic              eng_we,
  input  logic [PTR_W-1:0]  eng_widx,
  input  logic [7:0]        eng_wdata
);

  logic [BUF_BYTES*8-1:0] flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    logic [31:0] word_d;
    logic        word_en;

    always_comb begin
      word_d  = word_q;
      word_en = 1'b0;
      for (int b = 0; b < 4; b++) begin
        if (eng_we && (eng_widx == PTR_W'(w * 4 + b))) begin
          word_d[8*b +: 8] = eng_wdata;
          word_en          = 1'b1;
        end else if (cpu_we && (cpu_widx == WIDX_W'(w))) begin
          word_d[8*b +: 8] = cpu_wdata[8*b +: 8];
          word_en          = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign flat[32*w +: 32] = word_q;
  end

  assign cpu_rdata = flat[32*cpu_widx_r +: 32];
  assign eng_rdata = flat[8*eng_ridx +: 8];

  logic [WIDX_W-1:0] cpu_widx_r;
  assign cpu_widx_r = cpu_widx;

endmodule

// File: rtl/spi_mac_engine.sv
module spi_mac_engine
  import spi_mac_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8,
  parameter int DESEL_W   = 5,
  localparam int PTR_W    = $clog2(BUF_BYTES),
  localparam int SUM_W    = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_req,
  input  logic               soft_rst,
  input  logic [LEN_W-1:0]   out_len,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [DESEL_W-1:0] desel_cyc,
  output logic [PTR_W-1:0]   rd_idx,
  input  logic [7:0]         rd_byte,
  output logic               wr_en,
  output logic [PTR_W-1:0]   wr_idx,
  output logic [7:0]         wr_byte,
  output logic               accept,
  output logic               busy,
  output logic [3:0]         state_code,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);

  localparam logic [SUM_W-1:0] BUF_LIM = SUM_W'(BUF_BYTES);

  eng_state_e         st_q, st_d;
  logic [PTR_W-1:0]   pos_q, pos_d;
  logic [2:0]         bit_q, bit_d;
  logic               ph_q, ph_d;
  logic [7:0]         tx_q, tx_d;
  logic [7:0]         rx_q, rx_d;
  logic [DESEL_W-1:0] gap_q, gap_d;
  logic               busy_q, busy_d;
  logic               cs_n_q, cs_n_d;
  logic               sck_q, sck_d;

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] pos_ext;
  logic [SUM_W-1:0] olen_ext;
  logic [7:0]       rx_full;
  logic             last_byte;
  logic             next_is_out;

  assign total       = SUM_W'(out_len) + SUM_W'(in_len);
  assign pos_ext     = SUM_W'(pos_q);
  assign olen_ext    = SUM_W'(out_len);
  assign rx_full     = {rx_q[6:0], miso};
  assign last_byte   = (pos_ext + SUM_W'(1)) == total;
  assign next_is_out = (pos_ext + SUM_W'(1)) < olen_ext;

  assign accept = trig_req && (st_q == ST_IDLE) && (total != '0) && (total <= BUF_LIM);

  assign rd_idx  = (st_q == ST_SHIFT) ? (pos_q + PTR_W'(1)) : '0;
  assign wr_en   = (st_q == ST_SHIFT) && ph_q && (bit_q == 3'd7) && (pos_ext >= olen_ext);
  assign wr_idx  = pos_q;
  assign wr_byte = rx_full;

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    bit_d  = bit_q;
    ph_d   = ph_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    gap_d  = gap_q;
    busy_d = busy_q;
    cs_n_d = cs_n_q;
    sck_d  = sck_q;
    if (soft_rst) begin
      st_d   = ST_IDLE;
      busy_d = 1'b0;
      cs_n_d = 1'b1;
      sck_d  = 1'b0;
      ph_d   = 1'b0;
      tx_d   = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_d   = ST_SHIFT;
            busy_d = 1'b1;
            cs_n_d = 1'b0;
            pos_d  = '0;
            bit_d  = '0;
            ph_d   = 1'b0;
            tx_d   = (out_len != '0) ? rd_byte : 8'h00;
          end
        end
        ST_SHIFT: begin
          if (!ph_q) begin
            ph_d  = 1'b1;
            sck_d = 1'b1;
          end else begin
            ph_d  = 1'b0;
            sck_d = 1'b0;
            rx_d  = rx_full;
            if (bit_q == 3'd7) begin
              if (last_byte) begin
                st_d   = ST_GAP;
                cs_n_d = 1'b1;
                gap_d  = desel_cyc;
                tx_d   = '0;
              end else begin
                pos_d = pos_q + PTR_W'(1);
                bit_d = '0;
                tx_d  = next_is_out ? rd_byte : 8'h00;
              end
            end else begin
              bit_d = bit_q + 3'd1;
              tx_d  = {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_GAP: begin
          if (gap_q == '0) begin
            st_d   = ST_IDLE;
            busy_d = 1'b0;
          end else begin
            gap_d = gap_q - DESEL_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      bit_q  <= '0;
      ph_q   <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      gap_q  <= '0;
      busy_q <= 1'b0;
      cs_n_q <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      bit_q  <= bit_d;
      ph_q   <= ph_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      gap_q  <= gap_d;
      busy_q <= busy_d;
      cs_n_q <= cs_n_d;
      sck_q  <= sck_d;
    end
  end

  assign busy       = busy_q;
  assign state_code = st_q;
  assign sck        = sck_q;
  assign cs_n       = cs_n_q;
  assign mosi       = tx_q[7];

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q); // R6

  AST_MOSI_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && !$past(cs_n_q) && (mosi != $past(mosi))) |-> $past(sck_q)); // R6

  AST_CS_LOW_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> !cs_n_q); // R4

  AST_GAP_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (cs_n_q && busy_q)); // R7

  AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (st_q == ST_IDLE)); // R10

endmodule

// File: rtl/spi_mac_regs.sv
module spi_mac_regs
  import spi_mac_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8,
  parameter int DESEL_W   = 5,
  localparam int BUF_AW   = $clog2(BUF_BYTES),
  localparam int WIDX_W   = BUF_AW - 2,
  localparam int HI_W     = ADDR_W - BUF_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               buf_we,
  output logic [WIDX_W-1:0]  buf_widx,
  input  logic [31:0]        buf_rdata,
  output logic               trig_req,
  output logic               soft_rst,
  output logic [LEN_W-1:0]   out_len,
  output logic [LEN_W-1:0]   in_len,
  output logic [DESEL_W-1:0] desel_cyc,
  input  logic               accept,
  input  logic               busy,
  input  logic [3:0]         state_code
);

  localparam logic [HI_W-1:0] BUF_TAG = HI_W'(OFS_BUF >> BUF_AW);

  logic hit_ctl, hit_olen, hit_ilen, hit_misc, hit_stat, hit_buf;
  logic wr_ctl, wr_olen, wr_ilen, wr_misc;

  logic               en_q, en_d;
  logic               ready_q, ready_d;
  logic [LEN_W-1:0]   olen_q, ilen_q;
  logic [1:0]         rdlat_q, latch_q;
  logic [DESEL_W-1:0] desel_q;
  logic [31:0]        misc_rd;

  assign hit_ctl  = reg_addr == ADDR_W'(OFS_CTL);
  assign hit_olen = reg_addr == ADDR_W'(OFS_OLEN);
  assign hit_ilen = reg_addr == ADDR_W'(OFS_ILEN);
  assign hit_misc = reg_addr == ADDR_W'(OFS_MISC);
  assign hit_stat = reg_addr == ADDR_W'(OFS_STAT);
  assign hit_buf  = reg_addr[ADDR_W-1:BUF_AW] == BUF_TAG;

  assign wr_ctl  = reg_we && hit_ctl;
  assign wr_olen = reg_we && hit_olen;
  assign wr_ilen = reg_we && hit_ilen;
  assign wr_misc = reg_we && hit_misc;

  assign buf_we   = reg_we && hit_buf;
  assign buf_widx = reg_addr[BUF_AW-1:2];

  assign trig_req = wr_ctl && reg_wdata[CTL_EN] && reg_wdata[CTL_TRIG];
  assign soft_rst = wr_misc && reg_wdata[MISC_SWRST];

  always_comb begin
    en_d    = wr_ctl ? reg_wdata[CTL_EN] : en_q;
    ready_d = ready_q;
    if (soft_rst) begin
      ready_d = 1'b0;
    end else if (accept) begin
      ready_d = 1'b1;
    end else if (wr_ctl && !reg_wdata[CTL_EN]) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olen_q <= '0;
    end else if (wr_olen) begin
      olen_q <= reg_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilen_q <= '0;
    end else if (wr_ilen) begin
      ilen_q <= reg_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdlat_q <= '0;
      latch_q <= '0;
      desel_q <= '0;
    end else if (wr_misc) begin
      rdlat_q <= reg_wdata[26:25];
      latch_q <= reg_wdata[9:8];
      desel_q <= reg_wdata[DESEL_W-1:0];
    end
  end

  always_comb begin
    misc_rd                = '0;
    misc_rd[26:25]         = rdlat_q;
    misc_rd[9:8]           = latch_q;
    misc_rd[DESEL_W-1:0]   = desel_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctl) begin
      reg_rdata[CTL_EN] = en_q;
      reg_rdata[1]      = ready_q;
      reg_rdata[0]      = busy;
    end else if (hit_olen) begin
      reg_rdata[LEN_W-1:0] = olen_q;
    end else if (hit_ilen) begin
      reg_rdata[LEN_W-1:0] = ilen_q;
    end else if (hit_misc) begin
      reg_rdata = misc_rd;
    end else if (hit_stat) begin
      reg_rdata[3:0] = state_code;
    end else if (hit_buf) begin
      reg_rdata = buf_rdata;
    end
  end

  assign out_len   = olen_q;
  assign in_len    = ilen_q;
  assign desel_cyc = desel_q;

  AST_READY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ready_q); // R3

  AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ready_q && !busy && (state_code == 4'd0))); // R8

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !reg_wdata[CTL_EN]) |=> !$rose(busy)); // R2

endmodule

// File: rtl/spi_macro_engine.sv
module spi_macro_engine #(
  parameter int ADDR_W    = 12,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8,
  parameter int DESEL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int PTR_W  = $clog2(BUF_BYTES);
  localparam int WIDX_W = PTR_W - 2;

  logic               buf_we;
  logic [WIDX_W-1:0]  buf_widx;
  logic [31:0]        buf_rdata;
  logic               trig_req, soft_rst, accept, busy;
  logic [LEN_W-1:0]   out_len, in_len;
  logic [DESEL_W-1:0] desel_cyc;
  logic [3:0]         state_code;
  logic [PTR_W-1:0]   eng_ridx, eng_widx;
  logic [7:0]         eng_rbyte, eng_wbyte;
  logic               eng_we;

  spi_mac_regs #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .DESEL_W(DESEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_rdata(buf_rdata),
    .trig_req(trig_req), .soft_rst(soft_rst),
    .out_len(out_len), .in_len(in_len), .desel_cyc(desel_cyc),
    .accept(accept), .busy(busy), .state_code(state_code)
  );

  spi_mac_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(buf_we), .cpu_widx(buf_widx), .cpu_wdata(reg_wdata), .cpu_rdata(buf_rdata),
    .eng_ridx(eng_ridx), .eng_rdata(eng_rbyte),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wbyte)
  );

  spi_mac_engine #(
    .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .DESEL_W(DESEL_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .trig_req(trig_req), .soft_rst(soft_rst),
    .out_len(out_len), .in_len(in_len), .desel_cyc(desel_cyc),
    .rd_idx(eng_ridx), .rd_byte(eng_rbyte),
    .wr_en(eng_we), .wr_idx(eng_widx), .wr_byte(eng_wbyte),
    .accept(accept), .busy(busy), .state_code(state_code),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

endmodule

// File: tb/test_spi_macro_engine.sv
module test_spi_macro_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #5 clk = ~clk;

  spi_macro_engine i_spi_macro_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] eb   [128];
  logic [7:0] slv  [128];
  logic [7:0] mcap [128];

  int   cbit = 0, pulses = 0, cs_high = 0, last_gap = 0, mode0_err = 0;
  logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
  int   g_ol, g_il;

  // Slave model and wire monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      cbit = 0; pulses = 0; last_gap = cs_high;
    end
    if (spi_cs_n) cs_high++; else cs_high = 0;
    if (spi_cs_n && spi_sck) mode0_err++;
    if (!spi_cs_n && spi_sck && !prev_sck) begin
      if (spi_mosi !== prev_mosi) mode0_err++;
      if (cbit < 1024) mcap[cbit/8][7-(cbit%8)] = spi_mosi;
      cbit++; pulses++;
    end
    if (!spi_cs_n && !spi_sck) spi_miso = (cbit < 1024) ? slv[cbit/8][7-(cbit%8)] : 1'b0;
    prev_cs = spi_cs_n; prev_sck = spi_sck; prev_mosi = spi_mosi;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_word(input int w);
    return {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
  endfunction

  task automatic start_txn(input int ol, input int il, input int dsel);
    logic [31:0] d;
    g_ol = ol; g_il = il;
    bus_wr(12'h538, (32'd2 << 25) | (32'd1 << 8) | 32'(dsel));
    for (int w = 0; w < 32; w++) begin
      d = $urandom;
      {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]} = d;
      bus_wr(12'h800 + 12'(4*w), d);
    end
    for (int p = 0; p < 128; p++) slv[p] = 8'($urandom);
    bus_wr(12'h504, 32'(ol));
    bus_wr(12'h508, 32'(il));
    bus_wr(12'h500, 32'h8);
    bus_wr(12'h500, 32'hC);
    bus_rd(12'h500, d);
    check(d[1:0] == 2'b11, "R3 ready and in-progress after trigger", d, 32'hB);
    check(spi_cs_n == 1'b0, "R4 chip select low after start", 32'(spi_cs_n), 0);
    bus_rd(12'h550, d);
    check(d == 32'd1, "R10 status shifting", d, 1);
  endtask

  task automatic finish_txn(input int dsel);
    logic [31:0] d;
    int errs, tmo, rise_gap;
    tmo = 0; rise_gap = -1;
    d = 32'h1;
    while (d[0] && tmo < 5000) begin
      @(negedge clk);
      bus_rd(12'h500, d);
      if (spi_cs_n && rise_gap < 0 && d[0]) rise_gap = 0;
      else if (rise_gap >= 0 && d[0]) rise_gap++;
      tmo++;
    end
    check(d[1:0] == 2'b10, "R3 ready held, in-progress cleared", d, 32'hA);
    check(rise_gap >= dsel, "R7 in-progress held through deselect", 32'(rise_gap), 32'(dsel));
    check(pulses == 8*(g_ol+g_il), "R4 clock pulse count", 32'(pulses), 32'(8*(g_ol+g_il)));
    errs = 0;
    for (int p = 0; p < g_ol; p++) if (mcap[p] !== eb[p]) errs++;
    check(errs == 0, "R4 output bytes MSB first", 32'(errs), 0);
    check(mode0_err == 0, "R6 mode 0 timing", 32'(mode0_err), 0);
    for (int p = g_ol; p < g_ol+g_il; p++) eb[p] = slv[p];
    for (int w = 0; w < 32; w++) begin
      bus_rd(12'h800 + 12'(4*w), d);
      check(d == exp_word(w), "R5 buffer after receive", d, exp_word(w));
    end
    bus_rd(12'h550, d);
    check(d == 32'd0, "R10 status idle", d, 0);
    bus_wr(12'h500, 32'h0);
    bus_rd(12'h500, d);
    check(d[1:0] == 2'b00, "R3 ready cleared by disable", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ol, il;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins at reset", {spi_cs_n, spi_sck}, 32'h2);
    bus_rd(12'h500, d); check(d == 0, "R1 control at reset", d, 0);
    bus_rd(12'h538, d); check(d == 0, "R1 misc at reset", d, 0);
    bus_rd(12'h550, d); check(d == 0, "R1 status at reset", d, 0);

    // R9 / R11 readback
    bus_wr(12'h538, 32'hFFFF_FFFF);
    bus_rd(12'h538, d); check(d == 32'h0600_031F, "R9 misc field mask", d, 32'h0600_031F);
    bus_wr(12'h504, 32'h1A5);
    bus_rd(12'h504, d); check(d == 32'hA5, "R11 output length readback", d, 32'hA5);
    bus_wr(12'h508, 32'h3C);
    bus_rd(12'h508, d); check(d == 32'h3C, "R11 input length readback", d, 32'h3C);

    // R2 ignored triggers
    bus_wr(12'h504, 32'd4); bus_wr(12'h508, 32'd4);
    bus_wr(12'h500, 32'h4);
    bus_rd(12'h500, d);
    check(d[1:0] == 0 && spi_cs_n, "R2 trigger without enable", d, 0);
    bus_wr(12'h504, 32'd100); bus_wr(12'h508, 32'd29);
    bus_wr(12'h500, 32'hC);
    bus_rd(12'h500, d);
    check(d[1:0] == 0 && spi_cs_n, "R2 trigger with 129 bytes", d, 32'h8);
    bus_wr(12'h504, 32'd0); bus_wr(12'h508, 32'd0);
    bus_wr(12'h500, 32'hC);
    bus_rd(12'h500, d);
    check(d[1:0] == 0 && spi_cs_n, "R2 trigger with zero bytes", d, 32'h8);
    bus_wr(12'h500, 32'h0);

    // Directed frames
    start_txn(128, 0, 3);  finish_txn(3);
    start_txn(1, 127, 0);  finish_txn(0);
    start_txn(0, 5, 1);    finish_txn(1);
    start_txn(4, 4, 10);   finish_txn(10);

    // R7 back-to-back trigger with maximum deselect
    start_txn(2, 0, 31);
    d = 32'h1;
    while (d[0]) begin @(negedge clk); bus_rd(12'h500, d); end
    bus_wr(12'h500, 32'hC);
    @(negedge clk); @(negedge clk);
    check(last_gap >= 32, "R7 deselect gap", 32'(last_gap), 32);
    finish_txn(31);

    // R8 soft reset mid-frame
    start_txn(128, 0, 2);
    repeat (100) @(negedge clk);
    bus_wr(12'h538, (32'd1 << 28) | (32'd1 << 25) | (32'd2 << 8) | 32'd7);
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R8 pins after soft reset", {spi_cs_n, spi_sck}, 32'h2);
    bus_rd(12'h500, d); check(d[1:0] == 0, "R8 handshake cleared", d, 32'h8);
    bus_rd(12'h550, d); check(d == 0, "R8 status idle", d, 0);
    bus_rd(12'h538, d);
    check(d == 32'h0200_0207, "R8 R9 misc after soft reset", d, 32'h0200_0207);
    bus_wr(12'h500, 32'h0);

    // Constrained random frames
    for (int t = 0; t < 8; t++) begin
      ol = 1 + int'($urandom % 64);
      il = int'($urandom % (129 - ol));
      start_txn(ol, il, int'($urandom % 32));
      finish_txn(int'(i_dsel_dummy(ol)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  function automatic int i_dsel_dummy(input int x);
    return (x > 0) ? 0 : 0;
  endfunction

endmodule